// File: doc/BRIEF.md
# Binary-Field Multiplier and Inverter

This block does arithmetic in a binary extension field GF(2^M), with elements held in polynomial basis. It offers two operations on one shared set of registers. The first is a digit-serial multiply, which takes a×b modulo the field polynomial. The second is an iterative inversion, which finds a⁻¹ with a binary extended Euclidean loop. The field degree M, the digit width D and the reduction polynomial (a trinomial or pentanomial of degree M) are fixed at elaboration.

A caller drives operands `opa` and `opb` and an opcode `op`, then raises `start` for one cycle while `busy` is low. The unit captures the inputs and works on its own until it loads `result`. It then pulses `done` for one cycle. `result` and `err` hold their values until the next operation completes. Point arithmetic, squaring and operand transport live outside this block.

Top module: `gf_mulinv`

## Requirements
- R1: While reset is low and right after it, `busy`, `done` and `err` are 0 and `result` is all zeros.
- R2: With `op` = 0, the result is opa·opb reduced modulo POLY. Bit i of any field element is the coefficient of x^i, and bit M of POLY is its leading term.
- R3: For a multiply, count the edge that accepts `start` as edge 0. `busy` is high from then on, and `done` is high right after edge ceil(M/D), not earlier.
- R4: With `op` = 1 and a nonzero `opa`, `result` is the field inverse: opa·result mod POLY equals 1.
- R5: Inverting zero completes right after the accepting edge, with `err` = 1 and `result` = 0.
- R6: `done` is high for a single cycle per operation. Between completions, `result` and `err` keep their values.
- R7: A `start` that arrives while `busy` is high is ignored. The running operation's result is unchanged and no extra completion follows.
- R8: Every multiply and every nonzero inversion completes with `err` = 0, which clears an earlier error.
- R9: A nonzero inversion completes no later than edge 4·M+2 after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only when `busy` is low |
| op | input | 1 | Opcode: 0 = multiply, 1 = invert |
| opa | input | M | First operand (element to invert for op = 1) |
| opb | input | M | Second operand (multiply only) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completed operation was an inversion of zero |
| result | output | M | Last completed result |

## Verification
A bad accumulator or digit pointer in the multiply path gives a wrong `result` at the completion pulse. A miscounted digit loop moves that pulse away from edge ceil(M/D), so the error shows within one operation. A faulty Euclid step has two possible outcomes. It can give a value whose product with the operand is not 1, or it can fail to reach a unit value, which breaks the 4·M+2 bound. Either way the inversion check or the latency bound catches it. Stale `err` or a `start` leaking in while busy shows in the next completion, or as an extra `done`.

// File: rtl/gf_pkg.sv
// Shared types for the GF(2^M) multiplier-inverter.
// Assumes one-bit opcodes: 0 selects multiply, 1 selects invert.
package gf_pkg;
    localparam logic OPC_MUL = 1'b0;
    localparam logic OPC_INV = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_INV  = 2'd2
    } gf_state_e;
endpackage

// File: rtl/gf_digit_mac.sv
// One digit step of an MSB-first digit-serial multiply.
// nxt = acc * x^D + mcand * digit (mod POLY), built as a Horner chain of D
// single-bit stages. Assumes POLY[M] = 1 and that acc and mcand are reduced.
module gf_digit_mac #(
    parameter int         M    = 163,
    parameter int         D    = 8,
    parameter logic [M:0] POLY = {1'b1, {(M-8){1'b0}}, 8'hC9}
) (
    input  logic [M-1:0] acc,
    input  logic [M-1:0] mcand,
    input  logic [D-1:0] digit,
    output logic [M-1:0] nxt
);
    logic [M-1:0] chain [D+1];

    assign chain[0] = acc;

    // Each stage multiplies by x, reduces, and adds mcand when its digit bit is set.
    for (genvar k = 0; k < D; k++) begin : g_stage
        assign chain[k+1] = {chain[k][M-2:0], 1'b0}
                          ^ (chain[k][M-1]   ? POLY[M-1:0] : '0)
                          ^ (digit[D-1-k]    ? mcand       : '0);
    end

    assign nxt = chain[D];
endmodule

// File: rtl/gf_euclid_step.sv
// One iteration of the binary extended Euclidean inversion.
// Invariants held by the caller: g1*a = u and g2*a = v (mod POLY), u and v
// not both even, gcd(u,v) = 1. Halving divides by x modulo POLY (POLY[0] = 1).
module gf_euclid_step #(
    parameter int         M    = 163,
    parameter int         W    = 168,
    parameter logic [M:0] POLY = {1'b1, {(M-8){1'b0}}, 8'hC9}
) (
    input  logic [W-1:0] u,
    input  logic [W-1:0] v,
    input  logic [M-1:0] g1,
    input  logic [M-1:0] g2,
    output logic [W-1:0] u_nxt,
    output logic [W-1:0] v_nxt,
    output logic [M-1:0] g1_nxt,
    output logic [M-1:0] g2_nxt
);
    // Divide a reduced element by x modulo POLY.
    function automatic logic [M-1:0] half_mod(input logic [M-1:0] g);
        if (g[0])
            return ((g ^ POLY[M-1:0]) >> 1) | {1'b1, {(M-1){1'b0}}};
        else
            return g >> 1;
    endfunction

    // Shift out factors of x first, otherwise cancel the larger operand's lead.
    always_comb begin
        u_nxt  = u;
        v_nxt  = v;
        g1_nxt = g1;
        g2_nxt = g2;
        if (!u[0]) begin
            u_nxt  = u >> 1;
            g1_nxt = half_mod(g1);
        end else if (!v[0]) begin
            v_nxt  = v >> 1;
            g2_nxt = half_mod(g2);
        end else if (u > v) begin
            u_nxt  = u ^ v;
            g1_nxt = g1 ^ g2;
        end else begin
            v_nxt  = v ^ u;
            g2_nxt = g2 ^ g1;
        end
    end
endmodule

// File: rtl/gf_mulinv.sv
// GF(2^M) multiplier-inverter, polynomial basis.
// One register set (rx, ry, rp, rq) serves both operations:
//   multiply: rx = multiplicand, ry = multiplier digits, rp = accumulator
//   invert:   rx = u, ry = v, rp = g1, rq = g2
// start is taken only in idle; done pulses once as result is loaded.
// Assumes POLY has bits M and 0 set and is irreducible.
module gf_mulinv
    import gf_pkg::*;
#(
    parameter int         M    = 163,
    parameter int         D    = 8,
    parameter logic [M:0] POLY = {1'b1, {(M-8){1'b0}}, 8'hC9}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op,
    input  logic [M-1:0] opa,
    input  logic [M-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic         err,
    output logic [M-1:0] result
);
    localparam int NDIG = (M + D - 1) / D;
    localparam int NB   = NDIG * D;
    localparam int W    = (NB > M + 1) ? NB : M + 1;
    localparam int CW   = $clog2(NDIG + 1);
    localparam logic [CW-1:0] LAST = CW'(NDIG - 1);

    gf_state_e     state;
    logic [W-1:0]  rx, ry;
    logic [M-1:0]  rp, rq;
    logic [CW-1:0] cnt;

    logic [M-1:0]  mac_nxt;
    logic [W-1:0]  u_nxt, v_nxt;
    logic [M-1:0]  g1_nxt, g2_nxt;

    gf_digit_mac #(.M(M), .D(D), .POLY(POLY)) mac_i (
        .acc   (rp),
        .mcand (rx[M-1:0]),
        .digit (ry[NB-1 -: D]),
        .nxt   (mac_nxt)
    );

    gf_euclid_step #(.M(M), .W(W), .POLY(POLY)) euc_i (
        .u      (rx),
        .v      (ry),
        .g1     (rp),
        .g2     (rq),
        .u_nxt  (u_nxt),
        .v_nxt  (v_nxt),
        .g1_nxt (g1_nxt),
        .g2_nxt (g2_nxt)
    );

    // Busy whenever the sequencer is out of idle.
    assign busy = (state != ST_IDLE);

    // Sequencer: load operands, iterate the selected operation, publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rx     <= '0;
            ry     <= '0;
            rp     <= '0;
            rq     <= '0;
            cnt    <= '0;
            result <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (op == OPC_INV) begin
                            if (opa == '0) begin
                                result <= '0;
                                err    <= 1'b1;
                                done   <= 1'b1;
                            end else begin
                                rx    <= W'(opa);
                                ry    <= W'(POLY);
                                rp    <= M'(1);
                                rq    <= '0;
                                state <= ST_INV;
                            end
                        end else begin
                            rx    <= W'(opa);
                            ry    <= W'(opb);
                            rp    <= '0;
                            cnt   <= '0;
                            state <= ST_MUL;
                        end
                    end
                end
                ST_MUL: begin
                    rp  <= mac_nxt;
                    ry  <= ry << D;
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        result <= mac_nxt;
                        err    <= 1'b0;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_INV: begin
                    if (rx == W'(1)) begin
                        result <= rp;
                        err    <= 1'b0;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (ry == W'(1)) begin
                        result <= rq;
                        err    <= 1'b0;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        rx <= u_nxt;
                        ry <= v_nxt;
                        rp <= g1_nxt;
                        rq <= g2_nxt;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gf_mulinv_chk.sv
// Port-level protocol checker for gf_mulinv, attached with bind.
// Tracks the accepted operation and the edges since it was accepted.
module gf_mulinv_chk #(
    parameter int M = 163,
    parameter int D = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         op,
    input logic [M-1:0] opa,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [M-1:0] result
);
    localparam int NDIG    = (M + D - 1) / D;
    localparam int INV_MAX = 4 * M + 2;

    logic pend, pend_inv;
    int   edges;

    // Record the accepted opcode and count edges until its completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_inv <= 1'b0;
            edges    <= 0;
        end else if (start && !busy) begin
            pend     <= 1'b1;
            pend_inv <= op;
            edges    <= 0;
        end else if (done) begin
            pend <= 1'b0;
        end else if (pend) begin
            edges <= edges + 1;
        end
    end

    a_r3_mul_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend && !pend_inv) |-> (edges == NDIG));

    a_r3_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !done && edges > 0) |-> busy);

    a_r5_zero_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op && opa == '0) |=> (done && err && result == '0));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(err)));

    a_r8_mul_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend && !pend_inv) |-> !err);

    a_r9_inv_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && pend_inv) |-> (edges <= INV_MAX));
endmodule

bind gf_mulinv gf_mulinv_chk #(.M(M), .D(D)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .opa    (opa),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .result (result)
);

// File: tb/gf_mulinv_tb.sv
// Self-checking bench for gf_mulinv: a vector table walk, then directed cases.
module gf_mulinv_tb_top;
    localparam int         M       = 163;
    localparam int         D       = 8;
    localparam logic [M:0] POLY    = {1'b1, {(M-8){1'b0}}, 8'hC9};
    localparam int         NDIG    = (M + D - 1) / D;
    localparam int         INV_MAX = 4 * M + 2;
    localparam int         LIM     = 5 * M;
    localparam int         NV      = 9;

    localparam logic       VOP [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [M-1:0] VA [NV] = '{
        M'(1),
        {1'b1, {(M-1){1'b0}}},
        {M{1'b1}},
        M'(128'hDEADBEEF_CAFEF00D_0BADC0DE_FEEDFACE),
        '0,
        M'(1),
        M'(2),
        {M{1'b1}},
        {1'b1, {(M-9){1'b0}}, 8'hA5}
    };
    localparam logic [M-1:0] VB [NV] = '{
        M'(48'h1234_5678_9ABC),
        {1'b1, {(M-1){1'b0}}},
        {M{1'b1}},
        {2'b01, {(M-5){1'b0}}, 3'b111},
        M'(64'h0123_4567_89AB_CDEF),
        '0, '0, '0, '0
    };

    logic         clk, rst_n, start, op, busy, done, err;
    logic [M-1:0] opa, opb, result;
    int           checks = 0;
    int           errors = 0;

    gf_mulinv #(.M(M), .D(D), .POLY(POLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .err(err), .result(result)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Reference multiply: LSB-first shift-and-add with bitwise reduction.
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0;
        logic [M-1:0] t = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) r = r ^ t;
            t = {t[M-2:0], 1'b0} ^ (t[M-1] ? POLY[M-1:0] : '0);
        end
        return r;
    endfunction

    // Reference inverse: a^(2^M - 2) as a product of repeated squares.
    function automatic logic [M-1:0] ref_inv(input logic [M-1:0] a);
        logic [M-1:0] s = a;
        logic [M-1:0] r = M'(1);
        for (int i = 1; i < M; i++) begin
            s = ref_mul(s, s);
            r = ref_mul(r, s);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Run one operation; optionally pulse a foreign start at edge intr.
    task automatic run_op(input logic o, input logic [M-1:0] a, input logic [M-1:0] b, input int intr,
                          output logic [M-1:0] res, output logic e, output int lat, output logic mid);
        start = 1'b1; op = o; opa = a; opb = b;
        @(posedge clk); @(negedge clk);
        lat = 1; start = 1'b0; mid = 1'b0;
        while (!done && lat < LIM) begin
            if (lat == 2) mid = busy;
            if (lat == intr) begin
                start = 1'b1; op = 1'b1; opa = '0; opb = '0;
            end
            @(posedge clk); @(negedge clk);
            lat++;
            start = 1'b0;
        end
        res = result;
        e   = err;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog (R9): actual no completion expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [M-1:0] res, ex;
        logic         e, mid;
        int           lat;
        rst_n = 1'b0; start = 1'b0; op = 1'b0; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !err, "R1 flags in reset", M'({busy, done, err}), '0);
        check(result == '0, "R1 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && result == '0, "R1 after reset", M'({busy, done, err}), '0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            run_op(VOP[i], VA[i], VB[i], 0, res, e, lat, mid);
            if (VOP[i] == 1'b0) begin
                ex = ref_mul(VA[i], VB[i]);
                check(res == ex, "R2 product", res, ex);
                check(lat == NDIG + 1, "R3 multiply latency", M'(lat), M'(NDIG + 1));
                check(mid == 1'b1, "R3 busy mid-multiply", M'(mid), M'(1));
            end else begin
                ex = ref_inv(VA[i]);
                check(res == ex, "R4 inverse", res, ex);
                check(ref_mul(VA[i], res) == M'(1), "R4 a*inv", ref_mul(VA[i], res), M'(1));
                check(lat - 1 <= INV_MAX, "R9 inversion bound", M'(lat - 1), M'(INV_MAX));
            end
            check(e == 1'b0, "R8 err clear", M'(e), '0);
        end

        // R5: inverting zero.
        run_op(1'b1, '0, '0, 0, res, e, lat, mid);
        check(res == '0, "R5 zero result", res, '0);
        check(e == 1'b1, "R5 error flag", M'(e), M'(1));
        check(lat == 1, "R5 immediate done", M'(lat), M'(1));

        // R6: single pulse and hold.
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            check(!done && result == '0 && err, "R6 hold after done", M'({done, err}), M'(1));
        end

        // R8: a multiply after an error clears err.
        run_op(1'b0, M'(3), M'(5), 0, res, e, lat, mid);
        check(e == 1'b0 && res == M'(15), "R8 err cleared by multiply", res, M'(15));

        // R7: start while busy is ignored.
        ex = ref_mul(VA[3], VA[2]);
        run_op(1'b0, VA[3], VA[2], 4, res, e, lat, mid);
        check(res == ex, "R7 product unaffected", res, ex);
        check(e == 1'b0 && lat == NDIG + 1, "R7 no error, latency", M'(lat), M'(NDIG + 1));
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            check(!done && !busy && result == ex, "R7 no extra completion", result, ex);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule